// File: doc/BRIEF.md
# Class-of-Service Aging Memory Arbiter

This block sits in front of a single memory controller and picks one of several pending initiator requests each cycle. A request carries a connection identifier and a 3-bit urgency value, where a smaller value is more urgent. Two lookup tables place each request in a service class. One table is indexed by the connection identifier and the other by the urgency value. The block reports the chosen requester, its identifier and its effective urgency on the memory side. The transfer completes when the memory side signals ready.

Each requester has its own wait counter. A request that belongs to a service class and has waited at least that class's cycle budget is promoted. It then competes as if its urgency were 0 until it is served. Requests without a class keep their own urgency for as long as they wait. The two lookup tables are loaded through per-entry write enables. Entries whose enable is low keep their value, so a single entry can be changed without reading the table first.

Top module: `cos_mem_arbiter`

## Requirements
- R1: Among valid requests, the one with the numerically smallest effective urgency (0 to 7) is selected, and `mem_pri` reports that effective urgency.
- R2: Table entries are 2 bits: 0 = no class, 1 = class one, 2 = class two, 3 = no class. The connection-identifier table entry `idmap_q[2*id+:2]` decides the class when it is 1 or 2. Otherwise the urgency table entry `pmap_q[2*pri+:2]` decides.
- R3: On a clock edge, table entry k takes its slice of write data only when its enable bit k is high. All other entries keep their value. `pmap_q` and `idmap_q` show the table contents.
- R4: A classed request whose wait count is at least its class's budget (`thr_cos1` or `thr_cos2`) competes with effective urgency 0.
- R5: A request with no class is never promoted, however long it waits.
- R6: At equal effective urgency the request with the larger wait count wins. At equal wait count the lowest requester index wins.
- R7: A wait counter starts at 0. It rises by one on each edge where its request is valid and not accepted. It clears on acceptance or when the request is not valid. It holds at 2^CNT_W-1 instead of wrapping.
- R8: `mem_valid` is high whenever any request is valid. At most one `req_ready` bit is high, and only for a valid requester while `mem_ready` is high.
- R9: After reset both tables read 0, all counters are 0, and with no valid request `mem_valid` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_id | input | N_REQ*ID_W | Connection identifier per requester |
| req_pri | input | N_REQ*3 | Urgency per requester, 0 most urgent |
| req_ready | output | N_REQ | Request accepted this cycle |
| mem_valid | output | 1 | A request is offered to memory |
| mem_sel | output | clog2(N_REQ) | Index of the offered requester |
| mem_id | output | ID_W | Identifier of the offered request |
| mem_pri | output | 3 | Effective urgency of the offered request |
| mem_ready | input | 1 | Memory side accepts the offered request |
| pmap_we | input | 8 | Per-entry write enables, urgency table |
| pmap_wdata | input | 16 | Write data, urgency table, 2 bits per entry |
| pmap_q | output | 16 | Urgency table contents |
| idmap_we | input | 2^ID_W | Per-entry write enables, identifier table |
| idmap_wdata | input | 2*2^ID_W | Write data, identifier table |
| idmap_q | output | 2*2^ID_W | Identifier table contents |
| thr_cos1 | input | CNT_W | Wait budget of class one |
| thr_cos2 | input | CNT_W | Wait budget of class two |

## Verification
Every cycle, the assertions check the one-grant rule and that grants go only to valid requesters. They also check that a table entry with its enable low keeps its value, that a counter clears after acceptance, and that a saturated counter stays saturated. The ordering decisions can only be shown by the bench's scenarios. These are urgency ordering, class lookup precedence, promotion at exactly the budget cycle for each class, the absence of promotion without a class, and age and index tie-breaks. Saturation against wraparound is also shown there, through which requester wins after a long stall.

// File: rtl/cosarb_pkg.sv
package cosarb_pkg;
  localparam int PRI_W = 3;
  localparam int PRI_N = 1 << PRI_W;
  typedef enum logic [1:0] {
    COS_NONE = 2'd0,
    COS_ONE  = 2'd1,
    COS_TWO  = 2'd2,
    COS_RSVD = 2'd3
  } cos_e;
endpackage

// File: rtl/cosarb_map.sv
module cosarb_map
  import cosarb_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int ID_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PRI_N-1:0]        pmap_we,
  input  logic [2*PRI_N-1:0]      pmap_wdata,
  input  logic [(1<<ID_W)-1:0]    idmap_we,
  input  logic [2*(1<<ID_W)-1:0]  idmap_wdata,
  input  logic [N_REQ*ID_W-1:0]   req_id,
  input  logic [N_REQ*PRI_W-1:0]  req_pri,
  output logic [2*PRI_N-1:0]      pmap_q,
  output logic [2*(1<<ID_W)-1:0]  idmap_q,
  output logic [2*N_REQ-1:0]      req_cos
);
  localparam int ID_N = 1 << ID_W;

  logic [2*PRI_N-1:0] ptab_q, ptab_d;
  logic [2*ID_N-1:0]  itab_q, itab_d;

  // next-state: only enabled entries take new data
  always_comb begin
    ptab_d = ptab_q;
    for (int k = 0; k < PRI_N; k++)
      if (pmap_we[k]) ptab_d[2*k +: 2] = pmap_wdata[2*k +: 2];
    itab_d = itab_q;
    for (int k = 0; k < ID_N; k++)
      if (idmap_we[k]) itab_d[2*k +: 2] = idmap_wdata[2*k +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptab_q <= '0;
      itab_q <= '0;
    end else begin
      ptab_q <= ptab_d;
      itab_q <= itab_d;
    end
  end

  assign pmap_q  = ptab_q;
  assign idmap_q = itab_q;

  // classification: identifier table first, urgency table second
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      logic [ID_W-1:0]  id;
      logic [PRI_W-1:0] pr;
      logic [1:0]       ic, pc;
      id = req_id[i*ID_W +: ID_W];
      pr = req_pri[i*PRI_W +: PRI_W];
      ic = itab_q[2*int'(id) +: 2];
      pc = ptab_q[2*int'(pr) +: 2];
      if (ic == COS_ONE || ic == COS_TWO)      req_cos[2*i +: 2] = ic;
      else if (pc == COS_ONE || pc == COS_TWO) req_cos[2*i +: 2] = pc;
      else                                     req_cos[2*i +: 2] = COS_NONE;
    end
  end

  genvar g;
  generate
    for (g = 0; g < PRI_N; g++) begin : g_pchk
      assert_pentry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pmap_we[g] |=> $stable(pmap_q[2*g +: 2]));
    end
    for (g = 0; g < ID_N; g++) begin : g_ichk
      assert_ientry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !idmap_we[g] |=> $stable(idmap_q[2*g +: 2]));
    end
  endgenerate
endmodule

// File: rtl/cosarb_age.sv
module cosarb_age #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ-1:0]       req_take,
  output logic [N_REQ*CNT_W-1:0] wait_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  genvar g;
  generate
    for (g = 0; g < N_REQ; g++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q;
        if (!req_valid[g] || req_take[g]) cnt_d = '0;
        else if (cnt_q != CNT_MAX)        cnt_d = cnt_q + 1'b1;
        else                              cnt_en = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign wait_cnt[g*CNT_W +: CNT_W] = cnt_q;

      assert_clear_on_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_take[g] |=> (wait_cnt[g*CNT_W +: CNT_W] == '0));
      assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[g] && !req_take[g] && wait_cnt[g*CNT_W +: CNT_W] == CNT_MAX)
        |=> (wait_cnt[g*CNT_W +: CNT_W] == CNT_MAX));
    end
  endgenerate
endmodule

// File: rtl/cosarb_pick.sv
module cosarb_pick
  import cosarb_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ*PRI_W-1:0] req_pri,
  input  logic [2*N_REQ-1:0]     req_cos,
  input  logic [N_REQ*CNT_W-1:0] wait_cnt,
  input  logic [CNT_W-1:0]       thr_cos1,
  input  logic [CNT_W-1:0]       thr_cos2,
  output logic                   any_valid,
  output logic [IDX_W-1:0]       sel_idx,
  output logic [N_REQ-1:0]       sel_onehot,
  output logic [PRI_W-1:0]       sel_pri
);
  logic [PRI_W-1:0] eff [N_REQ];
  logic [CNT_W-1:0] wt  [N_REQ];

  genvar g;
  generate
    for (g = 0; g < N_REQ; g++) begin : g_eff
      logic [1:0]       cos;
      logic [CNT_W-1:0] thr;
      logic             promo;
      assign cos   = req_cos[2*g +: 2];
      assign thr   = (cos == COS_ONE) ? thr_cos1 : thr_cos2;
      assign wt[g] = wait_cnt[g*CNT_W +: CNT_W];
      assign promo = (cos == COS_ONE || cos == COS_TWO) && (wt[g] >= thr);
      assign eff[g] = promo ? '0 : req_pri[g*PRI_W +: PRI_W];
    end
  endgenerate

  logic             found;
  logic [PRI_W-1:0] best_eff;
  logic [CNT_W-1:0] best_wait;

  always_comb begin
    found     = 1'b0;
    best_eff  = '0;
    best_wait = '0;
    sel_idx   = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_valid[i]) begin
        if (!found || eff[i] < best_eff ||
            (eff[i] == best_eff && wt[i] > best_wait)) begin
          found     = 1'b1;
          best_eff  = eff[i];
          best_wait = wt[i];
          sel_idx   = IDX_W'(i);
        end
      end
    end
    sel_onehot = '0;
    if (found) sel_onehot[sel_idx] = 1'b1;
  end

  assign any_valid = found;
  assign sel_pri   = best_eff;
endmodule

// File: rtl/cos_mem_arbiter.sv
module cos_mem_arbiter
  import cosarb_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int ID_W  = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int ID_N  = 1 << ID_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ*ID_W-1:0]  req_id,
  input  logic [N_REQ*PRI_W-1:0] req_pri,
  output logic [N_REQ-1:0]       req_ready,
  output logic                   mem_valid,
  output logic [IDX_W-1:0]       mem_sel,
  output logic [ID_W-1:0]        mem_id,
  output logic [PRI_W-1:0]       mem_pri,
  input  logic                   mem_ready,
  input  logic [PRI_N-1:0]       pmap_we,
  input  logic [2*PRI_N-1:0]     pmap_wdata,
  output logic [2*PRI_N-1:0]     pmap_q,
  input  logic [ID_N-1:0]        idmap_we,
  input  logic [2*ID_N-1:0]      idmap_wdata,
  output logic [2*ID_N-1:0]      idmap_q,
  input  logic [CNT_W-1:0]       thr_cos1,
  input  logic [CNT_W-1:0]       thr_cos2
);
  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i_n <= rst_m_q;
    end
  end

  logic [2*N_REQ-1:0]     req_cos;
  logic [N_REQ*CNT_W-1:0] wait_cnt;
  logic [N_REQ-1:0]       sel_onehot;
  logic [N_REQ-1:0]       take;

  cosarb_map #(.N_REQ(N_REQ), .ID_W(ID_W)) u_map (
    .clk(clk), .rst_n(rst_i_n),
    .pmap_we(pmap_we), .pmap_wdata(pmap_wdata),
    .idmap_we(idmap_we), .idmap_wdata(idmap_wdata),
    .req_id(req_id), .req_pri(req_pri),
    .pmap_q(pmap_q), .idmap_q(idmap_q), .req_cos(req_cos)
  );

  cosarb_age #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_age (
    .clk(clk), .rst_n(rst_i_n),
    .req_valid(req_valid), .req_take(take), .wait_cnt(wait_cnt)
  );

  cosarb_pick #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_pick (
    .req_valid(req_valid), .req_pri(req_pri), .req_cos(req_cos),
    .wait_cnt(wait_cnt), .thr_cos1(thr_cos1), .thr_cos2(thr_cos2),
    .any_valid(mem_valid), .sel_idx(mem_sel),
    .sel_onehot(sel_onehot), .sel_pri(mem_pri)
  );

  assign req_ready = mem_ready ? sel_onehot : '0;
  assign take      = req_ready & req_valid;
  assign mem_id    = req_id[int'(mem_sel)*ID_W +: ID_W];

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(req_ready));
  assert_grant_to_valid_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ready & ~req_valid) == '0);
  assert_grant_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mem_ready |-> (req_ready == '0));
  assert_offer_when_pending_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|req_valid) |-> mem_valid);
endmodule

// File: tb/sim_cos_mem_arbiter.sv
`timescale 1ns/1ps
module sim_cos_mem_arbiter;
  localparam int N = 4, IW = 4, CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_valid;
  logic [N*IW-1:0] req_id;
  logic [N*3-1:0]  req_pri;
  logic [N-1:0]  req_ready;
  logic          mem_valid;
  logic [1:0]    mem_sel;
  logic [IW-1:0] mem_id;
  logic [2:0]    mem_pri;
  logic          mem_ready;
  logic [7:0]    pmap_we;
  logic [15:0]   pmap_wdata, pmap_q;
  logic [15:0]   idmap_we;
  logic [31:0]   idmap_wdata, idmap_q;
  logic [CW-1:0] thr_cos1, thr_cos2;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cos_mem_arbiter #(.N_REQ(N), .ID_W(IW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_pri(req_pri), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_sel(mem_sel), .mem_id(mem_id), .mem_pri(mem_pri), .mem_ready(mem_ready),
    .pmap_we(pmap_we), .pmap_wdata(pmap_wdata), .pmap_q(pmap_q),
    .idmap_we(idmap_we), .idmap_wdata(idmap_wdata), .idmap_q(idmap_q),
    .thr_cos1(thr_cos1), .thr_cos2(thr_cos2)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample shortly after
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = '0; req_id = '0; req_pri = '0;
    pmap_we = '0; idmap_we = '0;
    tick();
  endtask

  task automatic set_req(input int i, input logic [2:0] p, input logic [IW-1:0] id);
    req_pri[i*3 +: 3] = p;
    req_id[i*IW +: IW] = id;
  endtask

  task automatic t_reset();
    check(pmap_q == 16'h0, "R9 pmap after reset", pmap_q, 0);
    check(idmap_q == 32'h0, "R9 idmap after reset", idmap_q, 0);
    check(mem_valid == 1'b0 && req_ready == '0, "R9 idle outputs", {mem_valid, req_ready}, 0);
  endtask

  task automatic t_write_enable();
    @(negedge clk);
    pmap_wdata = 16'hFFFF; pmap_we = 8'b0010_0000;
    idmap_wdata = 32'hAAAA_AAAA; idmap_we = 16'h0200;
    tick();
    pmap_we = '0; idmap_we = '0;
    check(pmap_q == 16'h0C00, "R3 single urgency entry", pmap_q, 16'h0C00);
    check(idmap_q == 32'h0008_0000, "R3 single identifier entry", idmap_q, 32'h0008_0000);
    @(negedge clk);
    pmap_wdata = 16'h4000; pmap_we = 8'b1010_0000;
    tick();
    pmap_we = '0;
    check(pmap_q == 16'h4000, "R3 two entries rewritten", pmap_q, 16'h4000);
  endtask

  task automatic t_urgency();
    idle();
    @(negedge clk);
    thr_cos1 = 8'hFF; thr_cos2 = 8'hFF; mem_ready = 1'b0;
    set_req(0, 3'd5, 4'd1); set_req(1, 3'd3, 4'd2);
    set_req(2, 3'd1, 4'd3); set_req(3, 3'd6, 4'd4);
    req_valid = 4'b1111;
    #1;
    check(mem_valid && mem_sel == 2'd2 && mem_pri == 3'd1, "R1 smallest urgency wins",
          {mem_sel, mem_pri}, {2'd2, 3'd1});
    check(mem_id == 4'd3, "R1 identifier of winner", mem_id, 3);
    check(req_ready == '0, "R8 no grant without mem_ready", req_ready, 0);
    mem_ready = 1'b1; #1;
    check(req_ready == 4'b0100, "R8 one grant to winner", req_ready, 4'b0100);
  endtask

  task automatic t_ties();
    idle();
    @(negedge clk);
    mem_ready = 1'b0;
    set_req(1, 3'd4, 4'd0); set_req(2, 3'd4, 4'd0);
    req_valid = 4'b0110; #1;
    check(mem_sel == 2'd1, "R6 equal age lowest index", mem_sel, 1);
    idle();
    @(negedge clk);
    set_req(1, 3'd4, 4'd0); set_req(2, 3'd4, 4'd0);
    req_valid = 4'b0100;
    tick(); tick(); tick();
    req_valid = 4'b0110; #1;
    check(mem_sel == 2'd2, "R6 older request wins tie", mem_sel, 2);
  endtask

  task automatic t_promote_cos1();
    idle();
    @(negedge clk);
    mem_ready = 1'b1; thr_cos1 = 8'd3; thr_cos2 = 8'd200;
    set_req(0, 3'd7, 4'd0); set_req(1, 3'd2, 4'd0);
    req_valid = 4'b0011; #1;
    for (int k = 0; k < 3; k++) begin
      check(mem_sel == 2'd1, "R4 not yet promoted", mem_sel, 1);
      tick();
    end
    check(mem_sel == 2'd0 && mem_pri == 3'd0 && req_ready == 4'b0001,
          "R4 class one promoted at budget", {mem_sel, mem_pri}, 0);
    tick();
    check(mem_sel == 2'd1, "R7 counter cleared on acceptance", mem_sel, 1);
  endtask

  task automatic t_no_class();
    int hits = 0;
    idle();
    @(negedge clk);
    mem_ready = 1'b1; thr_cos1 = 8'd0; thr_cos2 = 8'd0;
    set_req(0, 3'd6, 4'd0); set_req(1, 3'd2, 4'd0);
    req_valid = 4'b0011; #1;
    for (int k = 0; k < 20; k++) begin
      if (mem_sel == 2'd0) hits++;
      tick();
    end
    check(hits == 0, "R5 unclassed request never promoted", hits, 0);
  endtask

  task automatic t_id_precedence();
    idle();
    @(negedge clk);
    mem_ready = 1'b1; thr_cos1 = 8'd2; thr_cos2 = 8'd10;
    set_req(0, 3'd7, 4'd9); set_req(1, 3'd2, 4'd0);
    req_valid = 4'b0011; #1;
    for (int k = 0; k < 10; k++) begin
      if (k == 2 || k == 9)
        check(mem_sel == 2'd1, "R2 identifier class overrides urgency class", mem_sel, 1);
      tick();
    end
    check(mem_sel == 2'd0 && mem_pri == 3'd0, "R4 class two budget", {mem_sel, mem_pri}, 0);
  endtask

  task automatic t_saturate();
    idle();
    @(negedge clk);
    mem_ready = 1'b0; thr_cos1 = 8'hFF; thr_cos2 = 8'hFF;
    set_req(0, 3'd6, 4'd0); set_req(2, 3'd6, 4'd0);
    req_valid = 4'b0001;
    for (int k = 0; k < 50; k++) tick();
    req_valid = 4'b0101;
    for (int k = 0; k < 250; k++) tick();
    check(mem_sel == 2'd0, "R7 counter saturates instead of wrapping", mem_sel, 0);
    for (int k = 0; k < 10; k++) tick();
    check(mem_sel == 2'd0, "R6 both saturated lowest index", mem_sel, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = '0; req_id = '0; req_pri = '0; mem_ready = 1'b0;
    pmap_we = '0; pmap_wdata = '0; idmap_we = '0; idmap_wdata = '0;
    thr_cos1 = 8'hFF; thr_cos2 = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_write_enable();
    t_urgency();
    t_ties();
    t_promote_cos1();
    t_no_class();
    t_id_precedence();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule